// File: doc/BRIEF.md
# Serial Command Port for a Pair of Seconds Counters

This block is the slave side of a three-wire serial link that gives access to two 32-bit seconds counters: a free-running one and one that only advances while main power is present. The host raises an enable line, sends an 8-bit command on a serial clock, and then moves 32 data bits on the same clock. The command picks a counter and a direction. It can also schedule a clear of either counter, or both, and it can write a 3-bit oscillator trim value. The counters, the oscillator and the power switching sit outside this block. The block sends them a snapshot request, a parallel load strobe with its data, clear pulses and a trim write.

All three serial inputs are sampled by the system clock through synchronizers, and their edges are found by comparing successive samples. The bidirectional data pin appears as an input, an output and an output enable, and the pad logic sits outside the block. Read data comes from a copy of the counter taken at the end of the command, so the counter can keep ticking during a read without spoiling the result. Write data builds up in a buffer and reaches the counter in a single strobe.

Top module: `tw_port`

## Requirements
- R1: A transfer starts only on a rising edge of `ser_en`. While `ser_en` is low the port ignores the serial clock, and `ser_doe` is low within three system cycles of `ser_en` going low, which also aborts any transfer in progress.
- R2: Command and data bits move least significant bit first. Command bit 7 selects the continuous counter (select code 0), bit 6 selects the gated counter (select code 1), bit 2 requests a clear of the continuous counter, bit 1 requests a clear of the gated counter, and bit 0 is 1 for a read and 0 for a write. Each bit is taken on a rising edge of `ser_clk`.
- R3: A command with bits 7 and 6 both set produces one `trim_we` pulse, with `trim_val` equal to command bits 5 to 3. Every later clock in that transfer is ignored, and no data is driven.
- R4: Clear requests act only when `ser_en` falls after a complete command. They appear as one-cycle pulses on `clr_cont` and `clr_gated`, and both can fire together.
- R5: On a read, the selected counter is sampled at the 8th rising edge, with one `snap_req` pulse that carries `snap_sel`. The 32 bits sent out are those of that sample, whatever the counter input does later.
- R6: Read bit k is set up on the (k+1)th falling edge after the command, the first of which follows the 8th rising edge. `ser_doe` is high only while `ser_clk` is low.
- R7: On a write, 32 bits are gathered on rising edges. One `load_stb` pulse carrying the whole word and `load_sel` follows the 32nd of those edges.
- R8: Once the 32 data bits have moved, further clocks cause no strobe and no output drive until `ser_en` goes low and then high again.
- R9: While `vcc_ok` is low, the port produces no strobes, no snapshot and no output drive, and it discards any transfer and pending clears.
- R10: A write cut short before its 32nd bit loads nothing. Clears requested by its complete command still fire when `ser_en` falls.
- R11: A command that selects neither counter has no data phase. Only its clear requests take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Main supply above switchover threshold; low blocks the port |
| ser_en | input | 1 | Serial enable, active high |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial data to the pad |
| ser_doe | output | 1 | Pad output enable |
| cnt_cont_i | input | DW | Current value of the continuous counter |
| cnt_gated_i | input | DW | Current value of the gated counter |
| snap_req | output | 1 | Snapshot pulse for a read |
| snap_sel | output | 1 | Counter sampled by the snapshot (0 continuous, 1 gated) |
| load_stb | output | 1 | Parallel load pulse |
| load_sel | output | 1 | Counter to load (0 continuous, 1 gated) |
| load_data | output | DW | Word to load |
| clr_cont | output | 1 | Clear pulse for the continuous counter |
| clr_gated | output | 1 | Clear pulse for the gated counter |
| trim_we | output | 1 | Trim register write pulse |
| trim_val | output | 3 | Trim value |

## Verification
The assertions assume that `ser_en`, `ser_clk` and `ser_din` change slowly next to the system clock, so that each serial level lasts several system cycles and every edge is seen once. They also assume that `ser_din` stays stable across each rising serial edge. The bench holds each serial half period for ten system cycles and changes data only while the serial clock is low. It lowers `ser_en` only while the serial clock is high, and it changes `vcc_ok` only between transfers.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_DONE = 3'd4
  } tw_state_e;

  typedef struct packed {
    logic       go_trim;
    logic       go_rd;
    logic       go_wr;
    logic       sel_gated;
    logic [2:0] trim;
    logic       clr_c;
    logic       clr_g;
  } tw_cmd_t;

  localparam int unsigned CMD_BITS  = 8;
  localparam int unsigned TRIM_BITS = 3;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], d[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl[b]  = chain[STAGES-1];
    assign rise[b] = chain[STAGES-1] & ~prev;
    assign fall[b] = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/tw_cmd_decode.sv
module tw_cmd_decode
  import tw_pkg::*;
(
  input  logic [CMD_BITS-1:0] raw,
  output tw_cmd_t             cmd
);

  logic pick_c, pick_g, rd;

  always_comb begin
    pick_c        = raw[7];
    pick_g        = raw[6];
    rd            = raw[0];
    cmd.go_trim   = pick_c & pick_g;
    cmd.go_rd     = (pick_c ^ pick_g) & rd;
    cmd.go_wr     = (pick_c ^ pick_g) & ~rd;
    cmd.sel_gated = pick_g;
    cmd.trim      = raw[5:3];
    cmd.clr_c     = raw[2];
    cmd.clr_g     = raw[1];
  end

endmodule

// File: rtl/tw_readout.sv
module tw_readout #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap,
  input  logic [DW-1:0] snap_val,
  input  logic          shift,
  input  logic          drive_ok,
  input  logic          sclk_lvl,
  output logic          dout,
  output logic          doe
);

  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      dout <= 1'b0;
      doe  <= 1'b0;
    end else begin
      if (snap) begin
        hold <= snap_val;
      end else if (shift) begin
        dout <= hold[0];
        hold <= {1'b0, hold[DW-1:1]};
      end
      doe <= drive_ok & ~sclk_lvl;
    end
  end

  AST_SNAP_NOT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !(snap && shift)); // R5

endmodule

// File: rtl/tw_port.sv
module tw_port
  import tw_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vcc_ok,
  input  logic          ser_en,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          ser_dout,
  output logic          ser_doe,
  input  logic [DW-1:0] cnt_cont_i,
  input  logic [DW-1:0] cnt_gated_i,
  output logic          snap_req,
  output logic          snap_sel,
  output logic          load_stb,
  output logic          load_sel,
  output logic [DW-1:0] load_data,
  output logic          clr_cont,
  output logic          clr_gated,
  output logic          trim_we,
  output logic [TRIM_BITS-1:0] trim_val
);

  localparam int unsigned CBW = $clog2(CMD_BITS);
  localparam int unsigned DCW = $clog2(DW + 1);
  localparam logic [CBW-1:0] CMD_LAST  = CBW'(CMD_BITS - 1);
  localparam logic [DCW-1:0] DATA_LAST = DCW'(DW - 1);
  localparam logic [DCW-1:0] DATA_ALL  = DCW'(DW);

  // synchronized pins: bit 0 enable, bit 1 clock, bit 2 data
  logic [2:0] s_lvl, s_rise, s_fall;
  tw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    ({ser_din, ser_clk, ser_en}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  logic en_lvl, en_rise, en_fall, sck_lvl, sck_rise, sck_fall, din_lvl;
  assign en_lvl   = s_lvl[0];
  assign en_rise  = s_rise[0];
  assign en_fall  = s_fall[0];
  assign sck_lvl  = s_lvl[1];
  assign sck_rise = s_rise[1];
  assign sck_fall = s_fall[1];
  assign din_lvl  = s_lvl[2];

  tw_state_e          state;
  logic [CMD_BITS-1:0] cmd_sr;
  logic [CBW-1:0]     bcnt;
  logic [DCW-1:0]     dcnt;
  logic [DW-1:0]      wbuf;
  logic               sel_q;
  logic               pend_c, pend_g;

  logic [CMD_BITS-1:0] cmd_next;
  tw_cmd_t             dec;
  assign cmd_next = {din_lvl, cmd_sr[CMD_BITS-1:1]};

  tw_cmd_decode u_dec (
    .raw (cmd_next),
    .cmd (dec)
  );

  logic cmd_done, snap_go, rd_shift, drive_ok;
  assign cmd_done = (state == ST_CMD) && sck_rise && (bcnt == CMD_LAST);
  assign snap_go  = cmd_done && dec.go_rd;
  assign rd_shift = (state == ST_RD) && sck_fall && (dcnt != DATA_ALL);
  assign drive_ok = vcc_ok && en_lvl && (state == ST_RD) && (dcnt != '0);

  tw_readout #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .snap     (snap_go),
    .snap_val (dec.sel_gated ? cnt_gated_i : cnt_cont_i),
    .shift    (rd_shift),
    .drive_ok (drive_ok),
    .sclk_lvl (sck_lvl),
    .dout     (ser_dout),
    .doe      (ser_doe)
  );

  always_ff @(posedge clk) begin
    if (rst || !vcc_ok) begin
      state     <= ST_IDLE;
      cmd_sr    <= '0;
      bcnt      <= '0;
      dcnt      <= '0;
      wbuf      <= '0;
      sel_q     <= 1'b0;
      pend_c    <= 1'b0;
      pend_g    <= 1'b0;
      snap_req  <= 1'b0;
      snap_sel  <= 1'b0;
      load_stb  <= 1'b0;
      load_sel  <= 1'b0;
      load_data <= '0;
      clr_cont  <= 1'b0;
      clr_gated <= 1'b0;
      trim_we   <= 1'b0;
      trim_val  <= '0;
    end else begin
      snap_req  <= 1'b0;
      load_stb  <= 1'b0;
      clr_cont  <= 1'b0;
      clr_gated <= 1'b0;
      trim_we   <= 1'b0;
      if (!en_lvl) begin
        state <= ST_IDLE;
        if (en_fall) begin
          clr_cont  <= pend_c;
          clr_gated <= pend_g;
        end
        pend_c <= 1'b0;
        pend_g <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (en_rise) begin
              state <= ST_CMD;
              bcnt  <= '0;
              dcnt  <= '0;
            end
          end
          ST_CMD: begin
            if (sck_rise) begin
              cmd_sr <= cmd_next;
              bcnt   <= bcnt + 1'b1;
              if (bcnt == CMD_LAST) begin
                pend_c <= dec.clr_c;
                pend_g <= dec.clr_g;
                sel_q  <= dec.sel_gated;
                if (dec.go_trim) begin
                  trim_we  <= 1'b1;
                  trim_val <= dec.trim;
                  state    <= ST_DONE;
                end else if (dec.go_rd) begin
                  snap_req <= 1'b1;
                  snap_sel <= dec.sel_gated;
                  state    <= ST_RD;
                end else if (dec.go_wr) begin
                  state <= ST_WR;
                end else begin
                  state <= ST_DONE;
                end
              end
            end
          end
          ST_RD: begin
            if (rd_shift) begin
              dcnt <= dcnt + 1'b1;
            end else if (sck_rise && dcnt == DATA_ALL) begin
              state <= ST_DONE;
            end
          end
          ST_WR: begin
            if (sck_rise) begin
              wbuf <= {din_lvl, wbuf[DW-1:1]};
              dcnt <= dcnt + 1'b1;
              if (dcnt == DATA_LAST) begin
                load_stb  <= 1'b1;
                load_sel  <= sel_q;
                load_data <= {din_lvl, wbuf[DW-1:1]};
                state     <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_EN_LOW_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !en_lvl |=> !ser_doe); // R1
  AST_CLR_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (clr_cont || clr_gated) |-> $past(en_fall)); // R4
  AST_LOAD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> $past(sck_rise) && $past(state == ST_WR)); // R7
  AST_SNAP_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    snap_req |-> $past(sck_rise) && $past(state == ST_CMD)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({snap_req, load_stb, trim_we})); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> !(snap_req || load_stb || trim_we)); // R8
  AST_VCC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !vcc_ok |=> !(snap_req || load_stb || trim_we || clr_cont || clr_gated)); // R9
  AST_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    ser_doe |-> $past(state == ST_RD)); // R11

endmodule

// File: tb/tb_tw_port.sv
module tb_tw_port;

  localparam int DW = 32;
  localparam int H  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_ok = 1'b1;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_doe;
  logic [DW-1:0] cnt_cont_i = 32'h1234_5678;
  logic [DW-1:0] cnt_gated_i = 32'h0BAD_F00D;
  logic snap_req, snap_sel, load_stb, load_sel, clr_cont, clr_gated, trim_we;
  logic [DW-1:0] load_data;
  logic [2:0] trim_val;

  always #10 clk = ~clk;

  tw_port #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .vcc_ok(vcc_ok),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe),
    .cnt_cont_i(cnt_cont_i), .cnt_gated_i(cnt_gated_i),
    .snap_req(snap_req), .snap_sel(snap_sel),
    .load_stb(load_stb), .load_sel(load_sel), .load_data(load_data),
    .clr_cont(clr_cont), .clr_gated(clr_gated),
    .trim_we(trim_we), .trim_val(trim_val)
  );

  // event kinds: 1 snapshot(sel), 2 load continuous, 3 load gated, 4 trim, 5 clear {g,c}
  typedef struct {
    int          kind;
    logic [31:0] data;
    string       req;
  } ev_t;

  ev_t exp_q[$];
  int nchk = 0, nerr = 0, clr_seen = 0;
  bit ended = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [31:0] data, input string req);
    ev_t e;
    e.kind = kind; e.data = data; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic void observe(input int kind, input logic [31:0] data);
    ev_t e;
    if (exp_q.size() == 0) begin
      nchk++; nerr++;
      $display("FAIL unexpected event: actual kind %0d data %h expected none", kind, data);
    end else begin
      e = exp_q.pop_front();
      nchk++;
      if (e.kind != kind || e.data != data) begin
        nerr++;
        $display("FAIL %s: actual kind %0d data %h expected kind %0d data %h",
                 e.req, kind, data, e.kind, e.data);
      end
    end
  endfunction

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (!rst) begin
      if (snap_req) observe(1, {31'd0, snap_sel});
      if (load_stb) observe(load_sel ? 3 : 2, load_data);
      if (trim_we) observe(4, {29'd0, trim_val});
      if (clr_cont || clr_gated) begin
        clr_seen++;
        observe(5, {30'd0, clr_gated, clr_cont});
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    ser_clk = 1'b0; ser_en = 1'b1; wait_n(H);
  endtask

  task automatic end_xfer();
    ser_clk = 1'b1; wait_n(H);
    ser_en = 1'b0; wait_n(H);
    ser_clk = 1'b0; wait_n(H);
  endtask

  task automatic clk_bit(input logic d);
    ser_din = d; wait_n(H);
    ser_clk = 1'b1; wait_n(H);
    ser_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 0; i < 8; i++) clk_bit(c[i]);
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) clk_bit(w[i]);
  endtask

  // read nbits after the command; count drive faults
  task automatic read_bits(input int nbits, output logic [31:0] w, output int bad_low, output int bad_high);
    w = '0; bad_low = 0; bad_high = 0;
    for (int i = 0; i < nbits; i++) begin
      wait_n(H - 1);
      if (ser_doe !== 1'b1) bad_low++;
      w[i] = ser_dout;
      wait_n(1);
      ser_clk = 1'b1;
      wait_n(H / 2 + 1);
      if (ser_doe !== 1'b0) bad_high++;
      wait_n(H / 2 - 1);
      if (i < nbits - 1) ser_clk = 1'b0;
    end
  endtask

  task automatic idle_bits(input int nbits, output int drives);
    drives = 0;
    for (int i = 0; i < nbits; i++) begin
      wait_n(H);
      if (ser_doe !== 1'b0) drives++;
      ser_clk = 1'b1; wait_n(H);
      if (ser_doe !== 1'b0) drives++;
      ser_clk = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int bl, bh, dr, cs;
    wait_n(5);
    rst = 1'b0;
    wait_n(3);
    // R1 reset state
    check(ser_doe === 1'b0 && snap_req === 1'b0 && load_stb === 1'b0 && trim_we === 1'b0,
          "R1 reset outputs", {28'd0, ser_doe, snap_req, load_stb, trim_we}, 32'd0);

    // R5/R6 read continuous, counter moves during read
    expect_ev(1, 32'd0, "R5 snapshot continuous");
    begin_xfer();
    send_byte(8'h81);
    cnt_cont_i = 32'hFFFF_0000;
    read_bits(32, w, bl, bh);
    end_xfer();
    check(w === 32'h1234_5678, "R5 read data from snapshot", w, 32'h1234_5678);
    check(bl == 0, "R6 drive while clock low", bl, 0);
    check(bh == 0, "R6 tristate while clock high", bh, 0);

    // R2 read gated counter, selection by bit 6
    expect_ev(1, 32'd1, "R2 snapshot gated");
    begin_xfer();
    send_byte(8'h41);
    read_bits(32, w, bl, bh);
    end_xfer();
    check(w === 32'h0BAD_F00D, "R2 gated read data", w, 32'h0BAD_F00D);

    // R7/R8 write continuous, extra clocks ignored
    expect_ev(2, 32'hA5C3_0F12, "R7 load continuous");
    begin_xfer();
    send_byte(8'h80);
    send_word(32'hA5C3_0F12, 32);
    idle_bits(6, dr);
    end_xfer();
    check(dr == 0, "R8 no drive after data", dr, 0);

    // R7 write gated
    expect_ev(3, 32'h8000_0001, "R7 load gated LSB first");
    begin_xfer();
    send_byte(8'h40);
    send_word(32'h8000_0001, 32);
    end_xfer();

    // R10 interrupted write with gated clear
    expect_ev(5, 32'd2, "R10 clear after short write");
    begin_xfer();
    send_byte(8'h42);
    send_word(32'hDEAD_BEEF, 20);
    end_xfer();

    // R3 trim with read bit set: no data phase
    expect_ev(4, 32'd5, "R3 trim value");
    begin_xfer();
    send_byte(8'hE9);
    idle_bits(32, dr);
    end_xfer();
    check(dr == 0, "R3 no drive after trim", dr, 0);

    // R4/R11 both clears, deferred until enable falls
    expect_ev(5, 32'd3, "R4 both clears");
    begin_xfer();
    cs = clr_seen;
    send_byte(8'h07);
    idle_bits(4, dr);
    check(clr_seen == cs, "R4 clear not before enable falls", clr_seen, cs);
    check(dr == 0, "R11 no data phase", dr, 0);
    end_xfer();
    check(clr_seen == cs + 1, "R4 clear at enable fall", clr_seen, cs + 1);

    // R4 read plus clear of continuous
    cnt_cont_i = 32'h0000_00FF;
    expect_ev(1, 32'd0, "R4 snapshot before clear");
    expect_ev(5, 32'd1, "R4 continuous clear");
    begin_xfer();
    send_byte(8'h85);
    read_bits(32, w, bl, bh);
    end_xfer();
    check(w === 32'h0000_00FF, "R4 read with clear", w, 32'h0000_00FF);

    // R1 abort of a read
    expect_ev(1, 32'd1, "R1 snapshot before abort");
    begin_xfer();
    send_byte(8'h41);
    read_bits(10, w, bl, bh);
    ser_en = 1'b0; wait_n(4);
    check(ser_doe === 1'b0, "R1 drive off after enable low", ser_doe, 0);
    check(w[9:0] === 10'h00D, "R1 partial read bits", w[9:0], 10'h00D);
    ser_clk = 1'b0; wait_n(H);
    idle_bits(3, dr);
    check(dr == 0, "R1 clock ignored while disabled", dr, 0);

    // R9 supply low blocks everything
    vcc_ok = 1'b0; wait_n(H);
    begin_xfer();
    send_byte(8'h87);
    idle_bits(32, dr);
    end_xfer();
    check(dr == 0, "R9 no drive when supply low", dr, 0);
    begin_xfer();
    send_byte(8'h80);
    send_word(32'h1111_2222, 32);
    end_xfer();
    vcc_ok = 1'b1; wait_n(H);

    // R8 port usable again after a new enable cycle
    expect_ev(2, 32'h0000_0003, "R8 write after restart");
    begin_xfer();
    send_byte(8'h80);
    send_word(32'h0000_0003, 32);
    end_xfer();

    wait_n(20);
    check(exp_q.size() == 0, "R7 all expected events seen", exp_q.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

endmodule